// File: doc/BRIEF.md
# Address-Aliasing Memory Test Engine

This engine exercises a memory through a plain synchronous port during bring-up and looks for shorted, open or mis-multiplexed address lines. It destroys the memory contents. Each address in a chosen window is taken in turn as the target. The engine clears the target to zero. It then visits every address one bit away from the target and fills it with ones. After each such fill it reads the target back, which must still hold zero. Once the target has been used, it is set to all ones, so later targets sit on a uniform background. Flipping each address bit against every target in turn produces every worst-case transition on a row/column multiplexed address bus.

When requested, four data-pattern passes follow: zeros, ones, a walking one and a walking zero. Each pass fills the whole window and then verifies it. The first mismatch stops the run. The engine then reports the address it was checking and the neighbour whose write disturbed it.

Top module: `addr_alias_tester`

## Requirements
- R1: After reset, busy, done and error are low, both failure addresses are zero, and mem_we and mem_re stay low while no run is active.
- R2: A start pulse while not busy captures range_lo, range_hi and pattern_en and raises busy on the next cycle. A start pulse while busy has no effect on the access sequence.
- R3: For each target, the first access writes 0x00 to the target. The neighbours are then target XOR (1<<k) for k = 0 up to AW-1, lowest bit first.
- R4: A neighbour inside [range_lo, range_hi] takes three cycles: a write of 0xFF to it, then a read of the target, then an idle compare cycle. A neighbour outside the range takes one idle cycle. Memory read data is valid in the cycle after mem_re.
- R5: After the last neighbour, the target is written with 0xFF. The target then advances by one until range_hi has been handled.
- R6: A nonzero target read-back stops the run. error rises, busy falls, fail_target holds the target and fail_neighbor holds the neighbour just written.
- R7: With pattern_en captured high, four passes follow the address phase, in this order: all zeros, all ones, a single one at bit ((a - range_lo) mod DW), and the complement of that. Each pass writes the range in ascending order, then reads it in ascending order. Each read is followed by an idle compare cycle.
- R8: A pattern mismatch stops the run with error high. Both failure addresses then hold the failing address.
- R9: A run that completes without failure ends with done high and busy low. done and error, once raised, hold with no memory access until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run |
| pattern_en | input | 1 | Append the data-pattern passes |
| range_lo | input | AW | First address of the window |
| range_hi | input | AW | Last address of the window (not below range_lo) |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after mem_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished without failure |
| error | output | 1 | Run stopped on a failure |
| fail_target | output | AW | Address being checked at failure |
| fail_neighbor | output | AW | Disturbing address at failure |

## Verification
A corrupted target counter or address modifier shows up on the memory port within one or two cycles. It appears as a write or read at the wrong address, or as a neighbour step that is skipped or doubled. The bench compares every cycle of the port against a behavioural model, so such a fault is flagged at its first access. A wrong compare path shows up later. It appears as error rising in the wrong cycle, or as the wrong failure addresses under an injected address-line fault or a stuck data bit.

// File: rtl/addr_alias_tester.sv
module addr_alias_tester #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pattern_en,
  input  logic [AW-1:0] range_lo,
  input  logic [AW-1:0] range_hi,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] fail_target,
  output logic [AW-1:0] fail_neighbor
);
  localparam int RW = (DW > 1) ? $clog2(DW) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_WT, S_NB, S_RD, S_CK, S_FILL, S_PW, S_PR, S_PC, S_DONE, S_ERR
  } state_t;

  state_t        st;
  logic [AW-1:0] lo_q, hi_q, tgt, modf;
  logic          pat_q;
  logic [1:0]    pidx;

  logic [AW-1:0] nb, off;
  logic          nb_in;
  logic [DW-1:0] one_hot, pat_val;

  assign nb      = tgt ^ modf;
  assign nb_in   = (nb >= lo_q) && (nb <= hi_q);
  assign off     = tgt - lo_q;
  assign one_hot = {{(DW-1){1'b0}}, 1'b1} << off[RW-1:0];

  always_comb begin
    case (pidx)
      2'd0:    pat_val = '0;
      2'd1:    pat_val = '1;
      2'd2:    pat_val = one_hot;
      default: pat_val = ~one_hot;
    endcase
  end

  assign mem_we    = (st == S_WT) || (st == S_NB && nb_in) || (st == S_FILL) || (st == S_PW);
  assign mem_re    = (st == S_RD) || (st == S_PR);
  assign mem_addr  = (st == S_NB) ? nb : tgt;
  assign mem_wdata = (st == S_WT) ? '0 : (st == S_PW) ? pat_val : '1;
  assign done      = (st == S_DONE);
  assign error     = (st == S_ERR);
  assign busy      = !(st == S_IDLE || st == S_DONE || st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      lo_q          <= '0;
      hi_q          <= '0;
      pat_q         <= 1'b0;
      tgt           <= '0;
      modf          <= '0;
      pidx          <= '0;
      fail_target   <= '0;
      fail_neighbor <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_ERR: if (start) begin
          lo_q          <= range_lo;
          hi_q          <= range_hi;
          pat_q         <= pattern_en;
          tgt           <= range_lo;
          pidx          <= '0;
          fail_target   <= '0;
          fail_neighbor <= '0;
          st            <= S_WT;
        end
        S_WT: begin
          modf <= {{(AW-1){1'b0}}, 1'b1};
          st   <= S_NB;
        end
        S_NB: begin
          if (nb_in) st <= S_RD;
          else begin
            modf <= modf << 1;
            if (modf[AW-1]) st <= S_FILL;
          end
        end
        S_RD: st <= S_CK;
        S_CK: begin
          if (mem_rdata != '0) begin
            fail_target   <= tgt;
            fail_neighbor <= nb;
            st            <= S_ERR;
          end else begin
            modf <= modf << 1;
            st   <= modf[AW-1] ? S_FILL : S_NB;
          end
        end
        S_FILL: begin
          if (tgt == hi_q) begin
            tgt  <= lo_q;
            pidx <= '0;
            st   <= pat_q ? S_PW : S_DONE;
          end else begin
            tgt <= tgt + 1'b1;
            st  <= S_WT;
          end
        end
        S_PW: begin
          if (tgt == hi_q) begin
            tgt <= lo_q;
            st  <= S_PR;
          end else tgt <= tgt + 1'b1;
        end
        S_PR: st <= S_PC;
        S_PC: begin
          if (mem_rdata != pat_val) begin
            fail_target   <= tgt;
            fail_neighbor <= tgt;
            st            <= S_ERR;
          end else if (tgt == hi_q) begin
            tgt <= lo_q;
            if (pidx == 2'd3) st <= S_DONE;
            else begin
              pidx <= pidx + 1'b1;
              st   <= S_PW;
            end
          end else begin
            tgt <= tgt + 1'b1;
            st  <= S_PR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_alias_tester_sva.sv
module addr_alias_tester_sva #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic [AW-1:0] lo_q,
  input logic [AW-1:0] hi_q
);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  a_r4_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r4_compare_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (!mem_we && !mem_re));

  a_r2_access_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_addr >= lo_q && mem_addr <= hi_q));

  a_r9_busy_ends_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || error));

  a_r9_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  a_r6_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind addr_alias_tester addr_alias_tester_sva #(.AW(AW)) sva_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .busy(busy), .done(done), .error(error),
  .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/addr_alias_tester_tb_top.sv
`timescale 1ns/1ps
module addr_alias_tester_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          pattern_en = 1'b0;
  logic [AW-1:0] range_lo = '0, range_hi = '0;
  logic          mem_we, mem_re, busy, done, error;
  logic [AW-1:0] mem_addr, fail_target, fail_neighbor;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  addr_alias_tester #(.AW(AW), .DW(DW)) dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  int fault_kind = 0, f_bit = 0, f_addr = 0;
  logic clr = 1'b0;
  logic [DW-1:0] bm [N];
  logic [DW-1:0] mm [N];
  bit [15:0] qv [$];
  bit exp_err;
  int exp_ft, exp_fn;

  function automatic int pa(int a);
    return (fault_kind == 1) ? (a & ~(1 << f_bit)) : a;
  endfunction

  function automatic logic [DW-1:0] rdv(int a, logic [DW-1:0] v);
    return (fault_kind == 2 && pa(a) == f_addr) ? (v & ~(8'(1) << f_bit)) : v;
  endfunction

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < N; i++) bm[i] <= 8'h5A;
    end else begin
      if (mem_we) bm[pa(int'(mem_addr))] <= mem_wdata;
      if (mem_re) mem_rdata <= rdv(int'(mem_addr), bm[pa(int'(mem_addr))]);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic mw(int a, logic [7:0] d);
    qv.push_back({2'b10, 6'(a), d});
    mm[pa(a)] = d;
  endtask

  function automatic logic [7:0] mrd(int a);
    return rdv(a, mm[pa(a)]);
  endfunction

  function automatic logic [7:0] pat(int p, int a, int lo);
    logic [7:0] oh;
    oh = 8'h01 << ((a - lo) % 8);
    case (p)
      0: return 8'h00;
      1: return 8'hFF;
      2: return oh;
      default: return ~oh;
    endcase
  endfunction

  task automatic build(int lo, int hi, bit pe);
    qv.delete();
    exp_err = 0; exp_ft = 0; exp_fn = 0;
    for (int a = 0; a < N; a++) mm[a] = 8'h5A;
    for (int t = lo; t <= hi; t++) begin
      mw(t, 8'h00);
      for (int b = 0; b < AW; b++) begin
        int n = t ^ (1 << b);
        if (n >= lo && n <= hi) begin
          mw(n, 8'hFF);
          qv.push_back({2'b01, 6'(t), 8'h00});
          qv.push_back(16'h0);
          if (mrd(t) != 8'h00) begin
            exp_err = 1; exp_ft = t; exp_fn = n;
            return;
          end
        end else qv.push_back(16'h0);
      end
      mw(t, 8'hFF);
    end
    if (pe) begin
      for (int p = 0; p < 4; p++) begin
        for (int a = lo; a <= hi; a++) mw(a, pat(p, a, lo));
        for (int a = lo; a <= hi; a++) begin
          qv.push_back({2'b01, 6'(a), 8'h00});
          qv.push_back(16'h0);
          if (mrd(a) != pat(p, a, lo)) begin
            exp_err = 1; exp_ft = a; exp_fn = a;
            return;
          end
        end
      end
    end
  endtask

  task automatic run(string name, int lo, int hi, bit pe, int fk, int fb, int fa, bit restart);
    bit [15:0] act;
    fault_kind = fk; f_bit = fb; f_addr = fa;
    build(lo, hi, pe);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    range_lo = AW'(lo); range_hi = AW'(hi); pattern_en = pe; start = 1'b1;
    @(negedge clk); start = 1'b0;
    range_lo = '0; range_hi = '1; pattern_en = ~pe;
    foreach (qv[i]) begin
      act = {mem_we, mem_re, (mem_we || mem_re) ? mem_addr : 6'h0, mem_we ? mem_wdata : 8'h0};
      chk(act == qv[i] && busy, "R3 R4 R5 R7 access sequence", act, qv[i]);
      if (restart && i == 10) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (restart) chk(busy == 0 && done == 1, "R2 start while busy ignored", {busy, done}, 2'b01);
    chk(busy == 0, "R9 busy low at end", busy, 0);
    if (exp_err) begin
      chk(error == 1 && done == 0, "R6 R8 error raised", {error, done}, 2'b10);
      chk(fail_target == AW'(exp_ft), "R6 R8 fail_target", fail_target, exp_ft);
      chk(fail_neighbor == AW'(exp_fn), "R6 R8 fail_neighbor", fail_neighbor, exp_fn);
    end else begin
      chk(done == 1 && error == 0, "R9 done raised", {done, error}, 2'b10);
    end
    repeat (5) begin
      @(negedge clk);
      chk(!mem_we && !mem_re && (done == !exp_err) && (error == exp_err),
          "R9 status held quietly", {mem_we, mem_re, done, error}, {2'b00, !exp_err, exp_err});
    end
    $display("run %s: %0d cycles checked", name, qv.size());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error, "R1 status after reset", {busy, done, error}, 0);
    chk(!mem_we && !mem_re, "R1 no access in reset", {mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error && fail_target == 0 && fail_neighbor == 0,
        "R1 idle after reset", {busy, done, error, fail_target, fail_neighbor}, 0);
    chk(!mem_we && !mem_re, "R1 idle quiet", {mem_we, mem_re}, 0);

    run("full", 0, N - 1, 1'b0, 0, 0, 0, 1'b0);
    run("window_patterns", 5, 20, 1'b1, 0, 0, 0, 1'b0);
    run("restart_ignored", 3, 12, 1'b0, 0, 0, 0, 1'b1);
    run("addr_bit3_stuck", 0, N - 1, 1'b0, 1, 3, 0, 1'b0);
    run("addr_bit0_stuck", 8, 23, 1'b1, 1, 0, 0, 1'b0);
    run("data_stuck_patterns", 0, 15, 1'b1, 2, 2, 9, 1'b0);
    run("data_stuck_no_patterns", 0, 15, 1'b0, 2, 2, 9, 1'b0);
    run("single_addr", 7, 7, 1'b1, 0, 0, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule